// File: doc/BRIEF.md
# Segmented Memory Manager with Address Translation

This block places a segmented memory on top of one flat, word-addressed backing RAM. Software names each word with a pair of segment identifier and word offset, and every segment counts its offsets from zero. The block holds a table of identifiers. Each entry has a valid flag, a start address in the flat RAM and a length in words. Through that table it translates every access into a flat address and checks it against the segment's bounds.

Four request kinds arrive on one request port. A map request takes a word count and allocates that much new backing space. It clears the new space to zero one word per cycle and returns a newly chosen identifier. An unmap request frees an identifier so that a later map can use it again. An access request reads or writes one word of a segment. A load-program request replaces segment 0, the segment that holds the running code, with a private copy of another segment. The block does not reclaim freed backing space: space is taken from a pointer that only moves upward.

Top module: `segmem_xlate`

## Requirements
- R1: A map request that succeeds returns a nonzero identifier. While no freed identifiers are waiting, new identifiers are handed out in ascending order starting at 1.
- R2: Freed identifiers are used again before new ones, in the order in which they were freed.
- R3: Every word of a newly mapped segment reads as zero. A map of length L keeps `busy` high for exactly L cycles before its response.
- R4: An access whose offset is greater than or equal to the segment length, or whose identifier is unmapped, returns error code 1 and leaves the RAM unchanged. A successful access responds in the cycle after it is accepted, with `busy` staying low.
- R5: A word written at [id, offset] reads back at the same pair. Segments do not overlap.
- R6: Unmapping identifier 0 or an identifier that is not mapped returns error code 2 and changes no mapping.
- R7: After a successful unmap, an access to that identifier returns error code 1.
- R8: Load-program from a mapped nonzero segment of length L copies it into new space and points segment 0 at the copy. It keeps `busy` high for L+1 cycles. Later writes to the source do not change segment 0, and segment 0 takes the source's length.
- R9: Load-program naming segment 0 changes nothing and responds with code 0.
- R10: Load-program naming an unmapped identifier returns error code 2.
- R11: A map request returns error code 3 and consumes no identifier and no space when all identifiers are in use, or when the current fill pointer plus the length would exceed the RAM depth. A request that ends exactly at the RAM depth succeeds.
- R12: After reset, `busy` and `rsp_valid` are low. Segment 0 is mapped with length 0, so any access to it returns error code 1. Identifier allocation starts again at 1.

Operation codes on `req_op` are: 0 map, 1 unmap, 2 access, 3 load-program. Error codes on `rsp_err` are: 0 none, 1 bounds, 2 bad identifier, 3 out of resources. Requests are accepted only while `busy` is low. Every accepted request produces a one-cycle `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted when busy is low |
| req_op | input | 2 | Operation code |
| req_id | input | ID_W | Segment identifier (access, unmap, load-program) |
| req_arg | input | LEN_W | Word offset for access, length for map |
| req_we | input | 1 | Access is a write |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Fill or copy in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 2 | Error code of the response |
| rsp_id | output | ID_W | Identifier returned by a map |
| rsp_rdata | output | DATA_W | Read data of an access |

## Verification
The bench builds the block with a 64-word RAM and four identifiers. With so few identifiers, the pool runs out after three maps. With so little space, a single large map fills the RAM exactly to its last word, and the next map hits the space limit. Both out-of-resources paths can therefore be reached, and the exact-fit boundary can be tested, in a short run. The small RAM also keeps segments next to each other. An out-of-bounds write that was not blocked would therefore damage a neighbouring segment where the bench can see it.

// File: rtl/segmem_pkg.sv
package segmem_pkg;

   typedef enum logic [1:0] {
      OP_MAP      = 2'd0,
      OP_UNMAP    = 2'd1,
      OP_ACCESS   = 2'd2,
      OP_LOADPROG = 2'd3
   } seg_op_e;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_BOUNDS  = 2'd1,
      ERR_BADID   = 2'd2,
      ERR_NOSPACE = 2'd3
   } seg_err_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_COPY = 2'd2
   } seg_state_e;

endpackage

// File: rtl/segmem_idpool.sv
module segmem_idpool #(
   parameter int NUM_IDS = 16,
   localparam int ID_W = $clog2(NUM_IDS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pop_i,
   input  logic            push_i,
   input  logic [ID_W-1:0] push_id_i,
   output logic            avail_o,
   output logic [ID_W-1:0] next_id_o
);

   generate
      if (NUM_IDS < 2 || (NUM_IDS & (NUM_IDS - 1)) != 0) begin : g_bad_ids
         $error("segmem_idpool: NUM_IDS must be a power of two of at least 2");
      end
   endgenerate

   logic [ID_W-1:0] slots [NUM_IDS];
   logic [ID_W:0]   wr_ptr, rd_ptr, fresh;
   logic            empty, full, fresh_left;

   always_comb begin
      empty      = (wr_ptr == rd_ptr);
      full       = (wr_ptr[ID_W] != rd_ptr[ID_W]) &&
                   (wr_ptr[ID_W-1:0] == rd_ptr[ID_W-1:0]);
      fresh_left = (fresh < (ID_W+1)'(NUM_IDS));
      avail_o    = !empty || fresh_left;
      next_id_o  = !empty ? slots[rd_ptr[ID_W-1:0]] : fresh[ID_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fresh  <= (ID_W+1)'(1);
      end else begin
         if (pop_i) begin
            if (!empty) rd_ptr <= rd_ptr + 1'b1;
            else        fresh  <= fresh + 1'b1;
         end
         if (push_i) begin
            slots[wr_ptr[ID_W-1:0]] <= push_id_i;
            wr_ptr                  <= wr_ptr + 1'b1;
         end
      end
   end

   p_pop_when_avail_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> avail_o) else $error("identifier taken from an empty pool");

   p_push_has_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full) else $error("recycle queue overflow");

   p_push_not_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> (push_id_i != '0)) else $error("identifier 0 recycled");

endmodule

// File: rtl/segmem_ram.sv
module segmem_ram #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) cells[waddr_i] <= wdata_i;
      if (re_i) rdata_o <= cells[raddr_i];
   end

endmodule

// File: rtl/segmem_xlate.sv
module segmem_xlate
   import segmem_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   parameter int NUM_IDS = 16,
   localparam int ID_W   = $clog2(NUM_IDS),
   localparam int LEN_W  = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ID_W-1:0]   req_id,
   input  logic [LEN_W-1:0]  req_arg,
   input  logic              req_we,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              rsp_valid,
   output logic [1:0]        rsp_err,
   output logic [ID_W-1:0]   rsp_id,
   output logic [DATA_W-1:0] rsp_rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 2 || ADDR_W > 20) begin : g_bad_addr
         $error("segmem_xlate: ADDR_W out of supported range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("segmem_xlate: DATA_W must be positive");
      end
   endgenerate

   // segment table
   logic              tbl_valid [NUM_IDS];
   logic [ADDR_W-1:0] tbl_base  [NUM_IDS];
   logic [LEN_W-1:0]  tbl_len   [NUM_IDS];

   seg_state_e        state;
   logic [LEN_W-1:0]  bump, cnt, cur_len;
   logic [ADDR_W-1:0] cur_base, src_base;

   // decode
   seg_op_e           op;
   logic              fire, sel_valid, in_range, fits;
   logic              map_ok, unmap_ok, copy_go, acc_ok;
   logic [ADDR_W-1:0] sel_base;
   logic [LEN_W-1:0]  sel_len, need_len;
   logic [LEN_W:0]    need_end;

   logic              pool_avail;
   logic [ID_W-1:0]   pool_next;

   logic              ram_we, ram_re;
   logic [ADDR_W-1:0] ram_waddr, ram_raddr;
   logic [DATA_W-1:0] ram_wdata, ram_rdata;

   always_comb begin
      op        = seg_op_e'(req_op);
      fire      = req_valid && (state == ST_IDLE);
      sel_valid = tbl_valid[req_id];
      sel_base  = tbl_base[req_id];
      sel_len   = tbl_len[req_id];
      in_range  = sel_valid && (req_arg < sel_len);
      need_len  = (op == OP_MAP) ? req_arg : sel_len;
      need_end  = {1'b0, bump} + {1'b0, need_len};
      fits      = (need_end <= (LEN_W+1)'(DEPTH));
      map_ok    = fire && (op == OP_MAP) && pool_avail && fits;
      unmap_ok  = fire && (op == OP_UNMAP) && (req_id != '0) && sel_valid;
      copy_go   = fire && (op == OP_LOADPROG) && (req_id != '0) && sel_valid && fits;
      acc_ok    = fire && (op == OP_ACCESS) && in_range;
   end

   // RAM port steering
   always_comb begin
      ram_we    = 1'b0;
      ram_re    = 1'b0;
      ram_waddr = '0;
      ram_raddr = '0;
      ram_wdata = '0;
      unique case (state)
         ST_FILL: begin
            ram_we    = 1'b1;
            ram_waddr = cur_base + cnt[ADDR_W-1:0];
         end
         ST_COPY: begin
            if (cnt < cur_len) begin
               ram_re    = 1'b1;
               ram_raddr = src_base + cnt[ADDR_W-1:0];
            end
            if (cnt != '0) begin
               ram_we    = 1'b1;
               ram_waddr = cur_base + cnt[ADDR_W-1:0] - 1'b1;
               ram_wdata = ram_rdata;
            end
         end
         default: begin
            if (acc_ok) begin
               ram_we    = req_we;
               ram_re    = !req_we;
               ram_waddr = sel_base + req_arg[ADDR_W-1:0];
               ram_raddr = sel_base + req_arg[ADDR_W-1:0];
               ram_wdata = req_wdata;
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bump      <= '0;
         cnt       <= '0;
         cur_len   <= '0;
         cur_base  <= '0;
         src_base  <= '0;
         rsp_valid <= 1'b0;
         rsp_err   <= ERR_NONE;
         rsp_id    <= '0;
         for (int i = 0; i < NUM_IDS; i++) begin
            tbl_valid[i] <= (i == 0);
            tbl_base[i]  <= '0;
            tbl_len[i]   <= '0;
         end
      end else begin
         rsp_valid <= 1'b0;
         unique case (state)
            ST_IDLE: if (fire) begin
               rsp_valid <= 1'b1;
               rsp_err   <= ERR_NONE;
               rsp_id    <= '0;
               unique case (op)
                  OP_MAP: begin
                     if (!map_ok) begin
                        rsp_err <= ERR_NOSPACE;
                     end else begin
                        tbl_valid[pool_next] <= 1'b1;
                        tbl_base[pool_next]  <= bump[ADDR_W-1:0];
                        tbl_len[pool_next]   <= req_arg;
                        bump                 <= need_end[LEN_W-1:0];
                        rsp_id               <= pool_next;
                        if (req_arg != '0) begin
                           state     <= ST_FILL;
                           cnt       <= '0;
                           cur_base  <= bump[ADDR_W-1:0];
                           cur_len   <= req_arg;
                           rsp_valid <= 1'b0;
                        end
                     end
                  end
                  OP_UNMAP: begin
                     if (unmap_ok) tbl_valid[req_id] <= 1'b0;
                     else          rsp_err <= ERR_BADID;
                  end
                  OP_ACCESS: begin
                     if (!in_range) rsp_err <= ERR_BOUNDS;
                  end
                  default: begin
                     if (req_id == '0) begin
                        rsp_err <= ERR_NONE;
                     end else if (!sel_valid) begin
                        rsp_err <= ERR_BADID;
                     end else if (!copy_go) begin
                        rsp_err <= ERR_NOSPACE;
                     end else begin
                        state     <= ST_COPY;
                        cnt       <= '0;
                        cur_base  <= bump[ADDR_W-1:0];
                        cur_len   <= sel_len;
                        src_base  <= sel_base;
                        bump      <= need_end[LEN_W-1:0];
                        rsp_valid <= 1'b0;
                     end
                  end
               endcase
            end
            ST_FILL: begin
               cnt <= cnt + 1'b1;
               if (cnt == cur_len - LEN_W'(1)) begin
                  state     <= ST_IDLE;
                  rsp_valid <= 1'b1;
               end
            end
            default: begin
               cnt <= cnt + 1'b1;
               if (cnt == cur_len) begin
                  state       <= ST_IDLE;
                  rsp_valid   <= 1'b1;
                  tbl_base[0] <= cur_base;
                  tbl_len[0]  <= cur_len;
               end
            end
         endcase
      end
   end

   assign busy      = (state != ST_IDLE);
   assign rsp_rdata = ram_rdata;

   segmem_idpool #(.NUM_IDS(NUM_IDS)) i_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .pop_i     (map_ok),
      .push_i    (unmap_ok),
      .push_id_i (req_id),
      .avail_o   (pool_avail),
      .next_id_o (pool_next)
   );

   segmem_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ram (
      .clk     (clk),
      .we_i    (ram_we),
      .waddr_i (ram_waddr),
      .wdata_i (ram_wdata),
      .re_i    (ram_re),
      .raddr_i (ram_raddr),
      .rdata_o (ram_rdata)
   );

   p_map_id_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      map_ok |-> (pool_next != '0)) else $error("map handed out identifier 0");

   p_fill_holds_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (map_ok && req_arg != '0) |=> (busy && !rsp_valid))
      else $error("fill did not hold busy");

   p_bounds_no_ram_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && op == OP_ACCESS && !in_range) |-> (!ram_we && !ram_re))
      else $error("rejected access touched the RAM");

   p_access_next_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && op == OP_ACCESS) |=> (rsp_valid && !busy))
      else $error("access response late");

   p_copy_ends_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_COPY && cnt == cur_len) |=> (rsp_valid && rsp_err == ERR_NONE))
      else $error("copy did not finish cleanly");

   p_bump_only_grows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (bump >= $past(bump))) else $error("fill pointer moved back");

endmodule

// File: tb/test_segmem_xlate.sv
`timescale 1ns/1ps
module test_segmem_xlate;

   localparam int DATA_W  = 32;
   localparam int ADDR_W  = 6;
   localparam int NUM_IDS = 4;
   localparam int ID_W    = 2;
   localparam int LEN_W   = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [1:0]        req_op = '0;
   logic [ID_W-1:0]   req_id = '0;
   logic [LEN_W-1:0]  req_arg = '0;
   logic              req_we = 1'b0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              busy, rsp_valid;
   logic [1:0]        rsp_err;
   logic [ID_W-1:0]   rsp_id;
   logic [DATA_W-1:0] rsp_rdata;

   int nchk = 0;
   int nfail = 0;

   always #5 clk = ~clk;

   segmem_xlate #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_IDS(NUM_IDS)) i_segmem_xlate (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_id(req_id), .req_arg(req_arg), .req_we(req_we), .req_wdata(req_wdata),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_id(rsp_id),
      .rsp_rdata(rsp_rdata)
   );

   typedef struct packed {
      logic [1:0]  op;
      logic [1:0]  id;
      logic [6:0]  arg;
      logic        we;
      logic [31:0] wd;
      logic [1:0]  err;
      logic        chk_rd;
      logic [31:0] rd;
      logic        chk_id;
      logic [1:0]  xid;
      logic [23:0] tag;
   } vec_t;

   localparam int NV = 42;
   // op: 0 map, 1 unmap, 2 access, 3 load-program; err: 0 ok, 1 bounds, 2 bad id, 3 no space
   localparam vec_t VECS [NV] = '{
      '{2'd0, 2'd0, 7'd4,  1'b0, 32'h0,    2'd0, 1'b0, 32'h0,  1'b1, 2'd1, "R1"},
      '{2'd0, 2'd0, 7'd3,  1'b0, 32'h0,    2'd0, 1'b0, 32'h0,  1'b1, 2'd2, "R1"},
      '{2'd2, 2'd1, 7'd0,  1'b0, 32'h0,    2'd0, 1'b1, 32'h0,  1'b0, 2'd0, "R3"},
      '{2'd2, 2'd2, 7'd2,  1'b0, 32'h0,    2'd0, 1'b1, 32'h0,  1'b0, 2'd0, "R3"},
      '{2'd2, 2'd1, 7'd0,  1'b1, 32'h11,   2'd0, 1'b0, 32'h0,  1'b0, 2'd0, "R5"},
      '{2'd2, 2'd2, 7'd0,  1'b1, 32'h22,   2'd0, 1'b0, 32'h0,  1'b0, 2'd0, "R5"},
      '{2'd2, 2'd1, 7'd0,  1'b0, 32'h0,    2'd0, 1'b1, 32'h11, 1'b0, 2'd0, "R5"},
      '{2'd2, 2'd2, 7'd0,  1'b0, 32'h0,    2'd0, 1'b1, 32'h22, 1'b0, 2'd0, "R5"},
      '{2'd2, 2'd1, 7'd4,  1'b1, 32'hDEAD, 2'd1, 1'b0, 32'h0,  1'b0, 2'd0, "R4"},
      '{2'd2, 2'd2, 7'd0,  1'b0, 32'h0,    2'd0, 1'b1, 32'h22, 1'b0, 2'd0, "R4"},
      '{2'd2, 2'd3, 7'd0,  1'b1, 32'hBEEF, 2'd1, 1'b0, 32'h0,  1'b0, 2'd0, "R4"},
      '{2'd1, 2'd0, 7'd0,  1'b0, 32'h0,    2'd2, 1'b0, 32'h0,  1'b0, 2'd0, "R6"},
      '{2'd1, 2'd3, 7'd0,  1'b0, 32'h0,    2'd2, 1'b0, 32'h0,  1'b0, 2'd0, "R6"},
      '{2'd2, 2'd0, 7'd0,  1'b0, 32'h0,    2'd1, 1'b0, 32'h0,  1'b0, 2'd0, "R12"},
      '{2'd2, 2'd1, 7'd1,  1'b1, 32'hA5,   2'd0, 1'b0, 32'h0,  1'b0, 2'd0, "R5"},
      '{2'd3, 2'd1, 7'd0,  1'b0, 32'h0,    2'd0, 1'b0, 32'h0,  1'b0, 2'd0, "R8"},
      '{2'd2, 2'd0, 7'd0,  1'b0, 32'h0,    2'd0, 1'b1, 32'h11, 1'b0, 2'd0, "R8"},
      '{2'd2, 2'd0, 7'd1,  1'b0, 32'h0,    2'd0, 1'b1, 32'hA5, 1'b0, 2'd0, "R8"},
      '{2'd2, 2'd0, 7'd3,  1'b0, 32'h0,    2'd0, 1'b1, 32'h0,  1'b0, 2'd0, "R8"},
      '{2'd2, 2'd0, 7'd4,  1'b0, 32'h0,    2'd1, 1'b0, 32'h0,  1'b0, 2'd0, "R8"},
      '{2'd2, 2'd1, 7'd0,  1'b1, 32'h33,   2'd0, 1'b0, 32'h0,  1'b0, 2'd0, "R8"},
      '{2'd2, 2'd0, 7'd0,  1'b0, 32'h0,    2'd0, 1'b1, 32'h11, 1'b0, 2'd0, "R8"},
      '{2'd3, 2'd0, 7'd0,  1'b0, 32'h0,    2'd0, 1'b0, 32'h0,  1'b0, 2'd0, "R9"},
      '{2'd2, 2'd0, 7'd0,  1'b0, 32'h0,    2'd0, 1'b1, 32'h11, 1'b0, 2'd0, "R9"},
      '{2'd3, 2'd3, 7'd0,  1'b0, 32'h0,    2'd2, 1'b0, 32'h0,  1'b0, 2'd0, "R10"},
      '{2'd1, 2'd2, 7'd0,  1'b0, 32'h0,    2'd0, 1'b0, 32'h0,  1'b0, 2'd0, "R7"},
      '{2'd2, 2'd2, 7'd0,  1'b0, 32'h0,    2'd1, 1'b0, 32'h0,  1'b0, 2'd0, "R7"},
      '{2'd1, 2'd1, 7'd0,  1'b0, 32'h0,    2'd0, 1'b0, 32'h0,  1'b0, 2'd0, "R7"},
      '{2'd0, 2'd0, 7'd2,  1'b0, 32'h0,    2'd0, 1'b0, 32'h0,  1'b1, 2'd2, "R2"},
      '{2'd0, 2'd0, 7'd2,  1'b0, 32'h0,    2'd0, 1'b0, 32'h0,  1'b1, 2'd1, "R2"},
      '{2'd2, 2'd2, 7'd0,  1'b0, 32'h0,    2'd0, 1'b1, 32'h0,  1'b0, 2'd0, "R3"},
      '{2'd2, 2'd1, 7'd1,  1'b0, 32'h0,    2'd0, 1'b1, 32'h0,  1'b0, 2'd0, "R3"},
      '{2'd0, 2'd0, 7'd2,  1'b0, 32'h0,    2'd0, 1'b0, 32'h0,  1'b1, 2'd3, "R1"},
      '{2'd0, 2'd0, 7'd1,  1'b0, 32'h0,    2'd3, 1'b0, 32'h0,  1'b0, 2'd0, "R11"},
      '{2'd1, 2'd3, 7'd0,  1'b0, 32'h0,    2'd0, 1'b0, 32'h0,  1'b0, 2'd0, "R11"},
      '{2'd0, 2'd0, 7'd60, 1'b0, 32'h0,    2'd3, 1'b0, 32'h0,  1'b0, 2'd0, "R11"},
      '{2'd0, 2'd0, 7'd47, 1'b0, 32'h0,    2'd0, 1'b0, 32'h0,  1'b1, 2'd3, "R11"},
      '{2'd2, 2'd3, 7'd46, 1'b0, 32'h0,    2'd0, 1'b1, 32'h0,  1'b0, 2'd0, "R3"},
      '{2'd2, 2'd3, 7'd47, 1'b0, 32'h0,    2'd1, 1'b0, 32'h0,  1'b0, 2'd0, "R4"},
      '{2'd1, 2'd1, 7'd0,  1'b0, 32'h0,    2'd0, 1'b0, 32'h0,  1'b0, 2'd0, "R11"},
      '{2'd0, 2'd0, 7'd1,  1'b0, 32'h0,    2'd3, 1'b0, 32'h0,  1'b0, 2'd0, "R11"},
      '{2'd0, 2'd0, 7'd0,  1'b0, 32'h0,    2'd0, 1'b0, 32'h0,  1'b1, 2'd1, "R11"}
   };

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic run_req(input logic [1:0] op, input logic [1:0] id, input logic [6:0] arg,
                          input logic we, input logic [31:0] wd,
                          output logic [1:0] err, output logic [31:0] rd,
                          output logic [1:0] rid, output int bcy);
      int guard;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_id = id; req_arg = arg;
      req_we = we; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0; req_we = 1'b0;
      bcy = 0;
      guard = 0;
      while (!rsp_valid && guard < 500) begin
         if (busy) bcy++;
         guard++;
         @(negedge clk);
      end
      if (guard >= 500) begin
         nchk++; nfail++;
         $display("FAIL response timeout: actual none expected rsp_valid");
      end
      err = rsp_err; rd = rsp_rdata; rid = rsp_id;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      logic [1:0]  err, rid;
      logic [31:0] rd;
      int          bcy;

      do_reset();
      check("R12", "busy after reset", 32'(busy), 32'd0);
      check("R12", "rsp_valid after reset", 32'(rsp_valid), 32'd0);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = VECS[i];
         run_req(v.op, v.id, v.arg, v.we, v.wd, err, rd, rid, bcy);
         check(string'(v.tag), $sformatf("vec %0d err", i), 32'(err), 32'(v.err));
         if (v.chk_rd) check(string'(v.tag), $sformatf("vec %0d rdata", i), rd, v.rd);
         if (v.chk_id) check(string'(v.tag), $sformatf("vec %0d id", i), 32'(rid), 32'(v.xid));
      end

      // directed: reset clears table and pool (R12)
      do_reset();
      check("R12", "busy after second reset", 32'(busy), 32'd0);
      run_req(2'd2, 2'd1, 7'd0, 1'b0, 32'h0, err, rd, rid, bcy);
      check("R12", "stale id after reset", 32'(err), 32'd1);
      // map length 5: busy exactly 5 cycles (R3), fresh id restarts at 1 (R12)
      run_req(2'd0, 2'd0, 7'd5, 1'b0, 32'h0, err, rd, rid, bcy);
      check("R3", "fill busy cycles", 32'(bcy), 32'd5);
      check("R12", "first id after reset", 32'(rid), 32'd1);
      @(negedge clk);
      check("R3", "rsp_valid single pulse", 32'(rsp_valid), 32'd0);
      run_req(2'd2, 2'd1, 7'd4, 1'b1, 32'h77, err, rd, rid, bcy);
      check("R4", "access latency busy cycles", 32'(bcy), 32'd0);
      // load-program of length 5: busy 6 cycles (R8)
      run_req(2'd3, 2'd1, 7'd0, 1'b0, 32'h0, err, rd, rid, bcy);
      check("R8", "copy busy cycles", 32'(bcy), 32'd6);
      check("R8", "copy err", 32'(err), 32'd0);
      run_req(2'd2, 2'd0, 7'd4, 1'b0, 32'h0, err, rd, rid, bcy);
      check("R8", "copied last word", rd, 32'h77);
      // load-program of segment 0 finishes at once (R9)
      run_req(2'd3, 2'd0, 7'd0, 1'b0, 32'h0, err, rd, rid, bcy);
      check("R9", "no-op busy cycles", 32'(bcy), 32'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule